// File: doc/BRIEF.md
# Indexed Color Palette Register Interface

The block holds a 256-entry color lookup table in which every entry carries an 8-bit red, green and blue component. A host fills the table through a 16-byte window of write-only 32-bit registers. One register selects the entry to be written. A second register accepts the three components one after another. A hidden phase counter keeps track of which component comes next. When the blue component has been written, the entry pointer moves on, so a whole palette can be loaded with a single pointer write followed by a stream of data writes.

On the other side, a display pipeline presents an 8-bit pixel code every cycle and receives the registered 24-bit color one cycle later. Each component write shows up on that port on its own. The lookup does not wait for a complete triple.

Top module: `cmap_palette`

## Requirements
- R1: After reset, every entry reads back as red = green = blue = 0, except entry 255, which reads all three components as 0xFF. On the lookup port the color is packed as {red[23:16], green[15:8], blue[7:0]}.
- R2: A write to byte offset 0x0 loads the entry pointer from write data bits 31:24 and returns the component phase to red.
- R3: Writes to byte offset 0x4 take the component from write data bits 31:24. They store red, then green, then blue, in that order, into the entry named by the pointer. Bits 23:0 of the write data have no effect.
- R4: The blue write advances the pointer by one modulo 256, so entry 255 is followed by entry 0, and the phase returns to red.
- R5: A write to any offset other than 0x0 and 0x4 changes neither the table, the pointer nor the phase.
- R6: Every host read in the window returns zero and has no side effect on the pointer, the phase or the table.
- R7: A single component write changes only that component of the addressed entry. The change is visible on the lookup port without the rest of the triple being written.
- R8: The lookup port is synchronous. A code presented before clock edge N appears as a color after edge N. A component write accepted at edge N is reflected by a lookup sampled at edge N+1.
- R9: A pointer write in the middle of a triple abandons the sequence, and the next data write goes to red of the newly selected entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Host access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 32 | Write data; only bits 31:24 carry a value |
| bus_rdata | output | 32 | Read data, always zero |
| pix_code | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Registered color {R,G,B} of the code |

## Verification
On every cycle, the embedded assertions check how the pointer and phase move. A pointer write reloads the pointer and clears the phase. A data write steps the phase, or wraps it and advances the pointer. A write to any other offset leaves both untouched, and the phase never leaves its three legal values. The same assertions check that every accepted component write lands in its lane. What the bench scenarios alone can show is which colors come out of the lookup port: the reset contents, the red/green/blue ordering, the wrap from 255 to 0, partial-triple visibility, the restart after a pointer rewrite, and the silence of reads and stray offsets.

// File: rtl/cmap_pkg.sv
// Package: shared widths, register offsets and the component phase type
// for the palette block. Assumes a 4-bit byte offset inside the window.
package cmap_pkg;
    localparam int unsigned CM_ADDR_W = 4;
    localparam logic [CM_ADDR_W-1:0] OFS_POINTER = 4'h0;
    localparam logic [CM_ADDR_W-1:0] OFS_COLOR   = 4'h4;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } cm_phase_e;
endpackage

// File: rtl/cmap_host_if.sv
// Module: host register decoder. Holds the entry pointer and the component
// phase, and turns data-register writes into one-hot lane write strobes.
// Assumes full-word writes; size qualifiers do not exist on this bus.
module cmap_host_if
    import cmap_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8,
    parameter int unsigned LANES  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [CM_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [LANES-1:0]     lane_we,
    output logic [IDX_W-1:0]     lane_idx,
    output logic [COMP_W-1:0]    lane_val
);
    localparam int unsigned LOW_W = DATA_W - COMP_W;

    logic [IDX_W-1:0]  ptr_q;
    cm_phase_e         phase_q;
    logic              wr_ptr, wr_col;
    logic              unused_low;

    assign wr_ptr     = bus_valid && bus_write && (bus_addr == OFS_POINTER);
    assign wr_col     = bus_valid && bus_write && (bus_addr == OFS_COLOR);
    assign unused_low = ^bus_wdata[LOW_W-1:0];

    // Pointer and phase: reload on pointer write, step on data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            phase_q <= PH_RED;
        end else if (wr_ptr) begin
            ptr_q   <= bus_wdata[DATA_W-1 -: IDX_W];
            phase_q <= PH_RED;
        end else if (wr_col) begin
            case (phase_q)
                PH_RED:   phase_q <= PH_GREEN;
                PH_GREEN: phase_q <= PH_BLUE;
                default: begin
                    phase_q <= PH_RED;
                    ptr_q   <= ptr_q + 1'b1;
                end
            endcase
        end
    end

    // Lane strobes: one-hot on the current phase during a data write.
    always_comb begin
        lane_we = '0;
        if (wr_col && phase_q != 2'd3)
            lane_we[phase_q] = 1'b1;
    end

    assign lane_idx = ptr_q;
    assign lane_val = bus_wdata[DATA_W-1 -: COMP_W];

    a_r2_pointer_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr |=> (ptr_q == $past(bus_wdata[DATA_W-1 -: IDX_W])) && (phase_q == PH_RED));
    a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_col && phase_q != PH_BLUE) |=>
            (phase_q == cm_phase_e'($past(phase_q) + 2'd1)) && $stable(ptr_q));
    a_r4_blue_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_col && phase_q == PH_BLUE) |=>
            (ptr_q == $past(ptr_q) + 1'b1) && (phase_q == PH_RED));
    a_r5_stray_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !wr_ptr && !wr_col) |=> $stable(ptr_q) && $stable(phase_q));
    a_r3_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q != 2'd3);
    a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_we));
endmodule

// File: rtl/cmap_lane.sv
// Module: one color component lane of the table: DEPTH entries of COMP_W
// bits, one write port, and a registered read port for the display side.
// Assumes a synchronous reset of every entry; the last entry resets to
// all ones, every other entry to zero.
module cmap_lane #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [COMP_W-1:0] wval,
    input  logic [IDX_W-1:0]  raddr,
    output logic [COMP_W-1:0] rval
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [COMP_W-1:0] mem [DEPTH];

    // Storage: reset pattern, otherwise a single write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i == DEPTH - 1) ? {COMP_W{1'b1}} : '0;
        end else if (we) begin
            mem[waddr] <= wval;
        end
    end

    // Display read: one registered stage.
    always_ff @(posedge clk) begin
        if (!rst_n) rval <= '0;
        else        rval <= mem[raddr];
    end

    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wval));
endmodule

// File: rtl/cmap_palette.sv
// Module: top of the palette. Write-only host window feeding three
// component lanes; the display port reads all lanes in parallel.
// Assumes one host access per strobe cycle and a read data of zero.
module cmap_palette
    import cmap_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [CM_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [IDX_W-1:0]     pix_code,
    output logic [3*COMP_W-1:0]  pix_rgb
);
    localparam int unsigned LANES = 3;

    logic [LANES-1:0]  lane_we;
    logic [IDX_W-1:0]  lane_idx;
    logic [COMP_W-1:0] lane_val;

    assign bus_rdata = '0;

    cmap_host_if #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .COMP_W(COMP_W), .LANES(LANES)
    ) u_host (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .lane_we(lane_we), .lane_idx(lane_idx), .lane_val(lane_val)
    );

    // Lane c = 0 is red and sits in the top byte of the packed color.
    for (genvar c = 0; c < LANES; c++) begin : g_lane
        cmap_lane #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .we(lane_we[c]), .waddr(lane_idx), .wval(lane_val),
            .raddr(pix_code),
            .rval(pix_rgb[(LANES-1-c)*COMP_W +: COMP_W])
        );
    end
endmodule

// File: tb/sim_cmap_palette.sv
module sim_cmap_palette;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_code = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    cmap_palette u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_code(pix_code), .pix_rgb(pix_rgb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One host access; drive at negedge, accepted at the next posedge.
    task automatic bus_access(input logic wr, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // Look up a code: present it, sample the registered result one edge later.
    task automatic lookup(input logic [7:0] code, output logic [23:0] rgb);
        @(negedge clk);
        pix_code = code;
        @(negedge clk);
        rgb = pix_rgb;
    endtask

    task automatic expect_color(input string req, input logic [7:0] code, input logic [23:0] exp);
        logic [23:0] rgb;
        lookup(code, rgb);
        check(req, {8'h0, rgb}, {8'h0, exp});
    endtask

    task automatic t_reset_contents;  // R1
        int bad = 0;
        for (int i = 0; i < 256; i++) begin
            logic [23:0] rgb;
            lookup(i[7:0], rgb);
            if (rgb !== ((i == 255) ? 24'hFFFFFF : 24'h0)) bad++;
        end
        check("R1 reset contents mismatches", bad, 0);
        expect_color("R1 white entry", 8'hFF, 24'hFFFFFF);
    endtask

    task automatic t_triple;  // R2 R3 R7 R8
        bus_access(1'b1, 4'h0, 32'h1000_0000);
        bus_access(1'b1, 4'h4, 32'hA1FF_FFFF);
        expect_color("R7 red only", 8'h10, 24'hA10000);
        bus_access(1'b1, 4'h4, 32'hB200_1234);
        expect_color("R7 red+green", 8'h10, 24'hA1B200);
        bus_access(1'b1, 4'h4, 32'hC3AB_CDEF);
        expect_color("R3 full triple", 8'h10, 24'hA1B2C3);
        expect_color("R3 neighbour untouched", 8'h11, 24'h000000);
    endtask

    task automatic t_autoinc;  // R4
        bus_access(1'b1, 4'h4, 32'h1100_0000);
        bus_access(1'b1, 4'h4, 32'h2200_0000);
        bus_access(1'b1, 4'h4, 32'h3300_0000);
        expect_color("R4 next entry", 8'h11, 24'h112233);
        bus_access(1'b1, 4'h0, 32'hFF00_0000);
        bus_access(1'b1, 4'h4, 32'h0100_0000);
        bus_access(1'b1, 4'h4, 32'h0200_0000);
        bus_access(1'b1, 4'h4, 32'h0300_0000);
        bus_access(1'b1, 4'h4, 32'h7700_0000);
        expect_color("R4 entry 255", 8'hFF, 24'h010203);
        expect_color("R4 wrap to entry 0", 8'h00, 24'h770000);
    endtask

    task automatic t_stray;  // R5 R6
        bus_access(1'b1, 4'h0, 32'h2000_0000);
        bus_access(1'b1, 4'h8, 32'h5500_0000);
        bus_access(1'b1, 4'hC, 32'h6600_0000);
        bus_access(1'b1, 4'h5, 32'h6700_0000);
        bus_access(1'b0, 4'h4, 32'h9900_0000);
        check("R6 read data offset 4", bus_rdata, 32'h0);
        bus_access(1'b0, 4'h0, 32'h0);
        check("R6 read data offset 0", bus_rdata, 32'h0);
        expect_color("R5 stray writes ignored", 8'h20, 24'h000000);
        bus_access(1'b1, 4'h4, 32'h4400_0000);
        expect_color("R5 R6 phase still red, pointer 0x20", 8'h20, 24'h440000);
    endtask

    task automatic t_restart;  // R9
        bus_access(1'b1, 4'h0, 32'h3000_0000);
        bus_access(1'b1, 4'h4, 32'hAA00_0000);
        bus_access(1'b1, 4'h4, 32'hBB00_0000);
        bus_access(1'b1, 4'h0, 32'h3100_0000);
        bus_access(1'b1, 4'h4, 32'hCC00_0000);
        expect_color("R9 old entry keeps partial", 8'h30, 24'hAABB00);
        expect_color("R9 restart at red", 8'h31, 24'hCC0000);
    endtask

    task automatic t_latency;  // R8
        @(negedge clk);
        pix_code = 8'hFF;
        @(negedge clk);
        pix_code = 8'h10;
        check("R8 one-cycle result", {8'h0, pix_rgb}, 32'h00010203);
        @(negedge clk);
        check("R8 following code", {8'h0, pix_rgb}, 32'h00A1B2C3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lookup output after reset", {8'h0, pix_rgb}, 32'h0);
        check("R6 read data idle", bus_rdata, 32'h0);
        t_reset_contents();
        t_triple();
        t_autoinc();
        t_stray();
        t_restart();
        t_latency();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule